// File: doc/BRIEF.md
# Sector Transfer Length and Address Updater

This block sits between the command registers of a cartridge disk controller and a word-by-word transfer engine. When a read, read-without-header, write or write-check command is issued, it first decides whether the command may run at all. It checks that a cartridge is loaded, that a write is not aimed at a locked drive, that the requested sector exists and, for every function except read-without-header, that the requested cylinder is the one the heads sit on. A command that passes is handed to the engine as a start pulse with a length and a linear media word address. The length is the requested word count cut off at the end of the current track, so a transfer never moves to another head or cylinder.

When the engine reports completion, it returns the number of words it actually moved, plus fault and miscompare indications. The block then produces the register values the controller writes back: the residual word count, the advanced memory address split into a low bus-address word and a high extension field, and the advanced disk address. It also produces the error flags, and for writes the number of zero words the engine must append to finish the last sector. A rejected command completes on the cycle after it is issued, with the register values unchanged and the matching flags set.

Geometry follows the disk address word: sector in bits 5:0, head in bit 6, cylinder in bits 15:7. The track index is bits 15:6. Word counts are held negated, as a two's-complement 16-bit value.

Top module: `xfer_span_ctl`

## Requirements
- R1: After reset, busy, done and eng_start are 0, and every error flag and result output is 0.
- R2: A command issued while drv_loaded is 0 is rejected, whatever the function or lock state. It gives done one cycle after cmd_valid with err_incmp=1 and err_drv=err_hdr=0, no eng_start, and new_cnt, new_ba (cmd_ma bits 15:0 with bit 0 cleared), new_bae (cmd_ma bits 21:16) and new_da equal to the command inputs.
- R3: A write (function 5) to a loaded drive with drv_locked=1 is rejected with err_drv=1 and err_incmp=0, unchanged registers and no eng_start. A locked drive does not block reads (6, 7) or write-check (1).
- R4: For functions 1, 5 and 6, cmd_da bits 15:7 not equal to trk_pos bits 15:7 rejects the command with err_hdr=1 and err_incmp=1. Function 7 skips this comparison.
- R5: A sector field (cmd_da bits 5:0) of 40 or more rejects any function with err_hdr=1 and err_incmp=1.
- R6: An accepted command pulses eng_start for one cycle, one cycle after cmd_valid. eng_len is min(65536 − cmd_cnt, (40 − sector) × 128), so cmd_cnt=0 requests 65536 words.
- R7: eng_lba equals ((cylinder × 2 + head) × 40 + sector) × 128.
- R8: One cycle after eng_done, done pulses and new_cnt = (cmd_cnt + eng_moved) mod 65536. err_incmp is set exactly when that value is nonzero.
- R9: The memory address advances by 2 × eng_moved modulo 2^22. new_ba carries its bits 15:0 with bit 0 forced to 0, and new_bae carries bits 21:16.
- R10: new_da = cmd_da + ceil(eng_moved / 128), modulo 65536.
- R11: For a write, pad_words is the number of words from eng_moved up to the next multiple of 128 (0 when already aligned). For every other function it is 0.
- R12: eng_nxm at eng_done sets err_nxm for any function. eng_miscmp sets err_crc only for write-check (function 1).
- R13: While busy (from eng_start until done), cmd_valid is ignored: no new eng_start is issued, and the results reflect the command that started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command issue |
| cmd_func | input | 3 | Function: 1 write-check, 5 write, 6 read, 7 read without header |
| cmd_da | input | 16 | Disk address word: cylinder 15:7, head 6, sector 5:0 |
| trk_pos | input | 16 | Current head position, cylinder in bits 15:7 |
| cmd_cnt | input | 16 | Negated word count |
| cmd_ma | input | 22 | Byte memory address |
| drv_loaded | input | 1 | Cartridge loaded and spinning |
| drv_locked | input | 1 | Drive write-locked |
| eng_start | output | 1 | Start pulse to the transfer engine |
| eng_len | output | 17 | Words the engine may move |
| eng_lba | output | 23 | Linear media word address |
| eng_done | input | 1 | Engine completion pulse |
| eng_moved | input | 17 | Words actually moved |
| eng_nxm | input | 1 | Memory fault during transfer |
| eng_miscmp | input | 1 | Compare mismatch during write-check |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Results valid pulse |
| new_cnt | output | 16 | Updated negated word count |
| new_ba | output | 16 | Updated bus address, bit 0 zero |
| new_bae | output | 6 | Updated address extension, bits 21:16 |
| new_da | output | 16 | Updated disk address |
| pad_words | output | 7 | Zero words to append after a write |
| err_incmp | output | 1 | Transfer incomplete |
| err_hdr | output | 1 | Header (cylinder or sector) error |
| err_drv | output | 1 | Drive error (write to locked drive) |
| err_nxm | output | 1 | Nonexistent memory |
| err_crc | output | 1 | Write-check mismatch |

## Verification
The main function is driven with counts shorter than, equal to and longer than the room left on the track, including a zero count. This separates the track clip from the count arithmetic. Words-moved values that are exact multiples of a sector, partial sectors and short stops from memory faults separate the ceiling in the disk address step and the write padding from plain truncation. Rejection is tried with each cause alone and with causes combined, which exposes the check priority. A memory address next to the top of the 22-bit space shows whether the carry wraps or leaks, and a nonzero head with a nonzero cylinder shows whether the head bit enters the linear address.

// File: rtl/xfer_span_ctl.sv
module xfer_span_ctl #(
  parameter int SECT_PER_TRK   = 40,
  parameter int WORDS_PER_SECT = 128,
  parameter int MA_W           = 22,
  parameter int DA_W           = 16,
  parameter int CNT_W          = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [2:0]                cmd_func,
  input  logic [DA_W-1:0]           cmd_da,
  input  logic [DA_W-1:0]           trk_pos,
  input  logic [CNT_W-1:0]          cmd_cnt,
  input  logic [MA_W-1:0]           cmd_ma,
  input  logic                      drv_loaded,
  input  logic                      drv_locked,
  output logic                      eng_start,
  output logic [CNT_W:0]            eng_len,
  output logic [DA_W+$clog2(SECT_PER_TRK)+$clog2(WORDS_PER_SECT)-7:0] eng_lba,
  input  logic                      eng_done,
  input  logic [CNT_W:0]            eng_moved,
  input  logic                      eng_nxm,
  input  logic                      eng_miscmp,
  output logic                      busy,
  output logic                      done,
  output logic [CNT_W-1:0]          new_cnt,
  output logic [15:0]               new_ba,
  output logic [MA_W-17:0]          new_bae,
  output logic [DA_W-1:0]           new_da,
  output logic [$clog2(WORDS_PER_SECT)-1:0] pad_words,
  output logic                      err_incmp,
  output logic                      err_hdr,
  output logic                      err_drv,
  output logic                      err_nxm,
  output logic                      err_crc
);
  localparam int SHIFT = $clog2(WORDS_PER_SECT);
  localparam int LEN_W = CNT_W + 1;
  localparam int LBA_W = DA_W + $clog2(SECT_PER_TRK) + SHIFT - 6;
  localparam int MAX_LEN = SECT_PER_TRK * WORDS_PER_SECT;
  localparam logic [2:0] F_WCHK = 3'd1, F_WRITE = 3'd5, F_RNOHDR = 3'd7;

  logic [5:0]        sect;
  logic [DA_W-7:0]   trk;
  logic              cyl_ok, sect_ok, rej_unld, rej_lock, rej_hdr, reject;
  logic [LEN_W-1:0]  want, room, len;
  logic [LBA_W-1:0]  lba_sec;

  assign sect    = cmd_da[5:0];
  assign trk     = cmd_da[DA_W-1:6];
  assign cyl_ok  = (cmd_func == F_RNOHDR) || (cmd_da[DA_W-1:7] == trk_pos[DA_W-1:7]);
  assign sect_ok = 32'(sect) < 32'(SECT_PER_TRK);
  assign rej_unld = !drv_loaded;
  assign rej_lock = drv_loaded && drv_locked && (cmd_func == F_WRITE);
  assign rej_hdr  = drv_loaded && !rej_lock && !(cyl_ok && sect_ok);
  assign reject   = rej_unld || rej_lock || rej_hdr;

  assign want    = {1'b1, {CNT_W{1'b0}}} - {1'b0, cmd_cnt};
  assign room    = LEN_W'(32'(SECT_PER_TRK) - 32'(sect)) << SHIFT;
  assign len     = (want < room) ? want : room;
  assign lba_sec = LBA_W'(trk) * LBA_W'(SECT_PER_TRK) + LBA_W'(sect);

  logic [2:0]       func_q;
  logic [CNT_W-1:0] cnt_q;
  logic [MA_W-1:0]  ma_q;
  logic [DA_W-1:0]  da_q;

  logic [CNT_W-1:0] fin_cnt;
  logic [MA_W-1:0]  fin_ma;
  logic [DA_W-1:0]  fin_da;
  logic [SHIFT-1:0] tail;
  logic [SHIFT-1:0] pad_calc;

  assign fin_cnt  = cnt_q + CNT_W'(eng_moved);
  assign fin_ma   = ma_q + (MA_W'(eng_moved) << 1);
  assign fin_da   = da_q + DA_W'((eng_moved + LEN_W'(WORDS_PER_SECT - 1)) >> SHIFT);
  assign tail     = eng_moved[SHIFT-1:0];
  assign pad_calc = (func_q == F_WRITE && tail != '0) ? SHIFT'(WORDS_PER_SECT - 32'(tail)) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; eng_start <= 1'b0;
      eng_len <= '0; eng_lba <= '0;
      func_q <= '0; cnt_q <= '0; ma_q <= '0; da_q <= '0;
      new_cnt <= '0; new_ba <= '0; new_bae <= '0; new_da <= '0; pad_words <= '0;
      err_incmp <= 1'b0; err_hdr <= 1'b0; err_drv <= 1'b0; err_nxm <= 1'b0; err_crc <= 1'b0;
    end else begin
      done      <= 1'b0;
      eng_start <= 1'b0;
      if (!busy && cmd_valid) begin
        func_q <= cmd_func; cnt_q <= cmd_cnt; ma_q <= cmd_ma; da_q <= cmd_da;
        if (reject) begin
          done      <= 1'b1;
          new_cnt   <= cmd_cnt;
          new_ba    <= {cmd_ma[15:1], 1'b0};
          new_bae   <= cmd_ma[MA_W-1:16];
          new_da    <= cmd_da;
          pad_words <= '0;
          err_incmp <= rej_unld || rej_hdr;
          err_hdr   <= rej_hdr;
          err_drv   <= rej_lock;
          err_nxm   <= 1'b0;
          err_crc   <= 1'b0;
        end else begin
          busy      <= 1'b1;
          eng_start <= 1'b1;
          eng_len   <= len;
          eng_lba   <= lba_sec << SHIFT;
        end
      end else if (busy && eng_done) begin
        busy      <= 1'b0;
        done      <= 1'b1;
        new_cnt   <= fin_cnt;
        new_ba    <= {fin_ma[15:1], 1'b0};
        new_bae   <= fin_ma[MA_W-1:16];
        new_da    <= fin_da;
        pad_words <= pad_calc;
        err_incmp <= fin_cnt != '0;
        err_hdr   <= 1'b0;
        err_drv   <= 1'b0;
        err_nxm   <= eng_nxm;
        err_crc   <= eng_miscmp && (func_q == F_WCHK);
      end
    end
  end

  AST_START_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (eng_len != '0 && eng_len <= LEN_W'(MAX_LEN))); // R6
  AST_START_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R6
  AST_NO_START_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_start && done)); // R2
  AST_HDR_IMPLIES_INCMP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_hdr) |-> err_incmp); // R4
  AST_DRV_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_drv) |-> !err_hdr && !err_incmp); // R3
  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_done) |=> busy && !eng_start); // R13
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_BA_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (new_ba[0] == 1'b0)); // R9
endmodule

// File: tb/sim_xfer_span_ctl.sv
module sim_xfer_span_ctl;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [2:0] cmd_func = 0;
  logic [15:0] cmd_da = 0, trk_pos = 0, cmd_cnt = 0;
  logic [21:0] cmd_ma = 0;
  logic drv_loaded = 0, drv_locked = 0;
  logic eng_start;
  logic [16:0] eng_len;
  logic [22:0] eng_lba;
  logic eng_done = 0;
  logic [16:0] eng_moved = 0;
  logic eng_nxm = 0, eng_miscmp = 0;
  logic busy, done;
  logic [15:0] new_cnt, new_ba, new_da;
  logic [5:0] new_bae;
  logic [6:0] pad_words;
  logic err_incmp, err_hdr, err_drv, err_nxm, err_crc;

  int checks = 0, errors = 0;
  bit exp_busy = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  xfer_span_ctl u0 (.*);

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) chk("R13 busy per-clock", busy, exp_busy);

  task automatic do_cmd(input int f, input int da, input int hp, input int cnt, input int ma,
                        input bit ld, input bit lk, input int moved, input bit nxm,
                        input bit mis, input int dly, input bit poke);
    int sect, cyl, hcyl, track, want, room, len, fc, fma, fda, pad;
    bit rinc, rhdr, rdrv, rej;
    sect = da & 63; cyl = (da >> 7) & 511; hcyl = (hp >> 7) & 511; track = (da >> 6) & 1023;
    rinc = 0; rhdr = 0; rdrv = 0;
    if (!ld) rinc = 1;
    else if (f == 5 && lk) rdrv = 1;
    else if ((f != 7 && cyl != hcyl) || sect >= 40) begin rhdr = 1; rinc = 1; end
    rej = rinc | rhdr | rdrv;
    cmd_func = 3'(f); cmd_da = 16'(da); trk_pos = 16'(hp); cmd_cnt = 16'(cnt);
    cmd_ma = 22'(ma); drv_loaded = ld; drv_locked = lk; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    if (rej) begin
      chk("R2 reject done", done, 1);
      chk("R2 reject no start", eng_start, 0);
      chk("R2/R4 incmp", err_incmp, rinc);
      chk("R4/R5 hdr", err_hdr, rhdr);
      chk("R3 drv", err_drv, rdrv);
      chk("R2 cnt unchanged", new_cnt, cnt & 16'hFFFF);
      chk("R2 ba unchanged", new_ba, ma & 16'hFFFE);
      chk("R2 bae unchanged", new_bae, (ma >> 16) & 63);
      chk("R2 da unchanged", new_da, da & 16'hFFFF);
      @(negedge clk);
      chk("R2 done one cycle", done, 0);
      return;
    end
    want = 65536 - (cnt & 16'hFFFF);
    room = (40 - sect) * 128;
    len = (want < room) ? want : room;
    exp_busy = 1;
    chk("R6 start", eng_start, 1);
    chk("R6 len", eng_len, len);
    chk("R7 lba", eng_lba, (track * 40 + sect) * 128);
    for (int i = 0; i < dly; i++) begin
      if (poke && i == 0) begin
        cmd_func = 3'd6; cmd_da = 16'h0005; trk_pos = 16'h0000; cmd_cnt = 16'hFFFF;
        cmd_ma = 22'h1234; cmd_valid = 1;
      end
      @(negedge clk);
      cmd_valid = 0;
      chk("R13 no restart", eng_start, 0);
      chk("R13 no done", done, 0);
    end
    eng_done = 1; eng_moved = 17'(moved); eng_nxm = nxm; eng_miscmp = mis;
    @(posedge clk);
    exp_busy = 0;
    @(negedge clk);
    eng_done = 0; eng_nxm = 0; eng_miscmp = 0;
    fc = (cnt + moved) & 16'hFFFF;
    fma = (ma + 2 * moved) & 22'h3FFFFF;
    fda = (da + (moved + 127) / 128) & 16'hFFFF;
    pad = (f == 5 && (moved % 128) != 0) ? 128 - (moved % 128) : 0;
    chk("R8 done", done, 1);
    chk("R8 cnt", new_cnt, fc);
    chk("R8 incmp", err_incmp, fc != 0);
    chk("R9 ba", new_ba, fma & 16'hFFFE);
    chk("R9 bae", new_bae, fma >> 16);
    chk("R10 da", new_da, fda);
    chk("R11 pad", pad_words, pad);
    chk("R12 nxm", err_nxm, nxm);
    chk("R12 crc", err_crc, mis && f == 1);
    chk("R3/R4 no hdr drv", err_hdr | err_drv, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 start", eng_start, 0);
    chk("R1 flags", {err_incmp, err_hdr, err_drv, err_nxm, err_crc}, 0);
    chk("R1 results", new_cnt | new_ba | new_da | new_bae | pad_words, 0);
    rst_n = 1;
    @(negedge clk);
    // R6 R8 R10 full two-sector read
    do_cmd(6, 16'h0180, 16'h0180, 16'hFF00, 22'h001000, 1, 0, 256, 0, 0, 3, 0);
    // R6 clip at end of track, R7 head 1
    do_cmd(6, (3 << 7) | (1 << 6) | 38, 3 << 7, 16'hFE00, 22'h020000, 1, 0, 256, 0, 0, 2, 0);
    // R6 zero count means 65536, R7 cylinder 3 head 1 sector 5
    do_cmd(6, (3 << 7) | (1 << 6) | 5, 3 << 7, 0, 22'h000100, 1, 0, 4480, 0, 0, 1, 0);
    do_cmd(6, 0, 0, 0, 0, 1, 0, 5120, 0, 0, 1, 0);
    // R11 write partial sector
    do_cmd(5, 16'h0082, 16'h0080, 16'hFF38, 22'h000400, 1, 0, 200, 0, 0, 2, 0);
    // R11 write aligned, R3 locked read proceeds
    do_cmd(5, 16'h0000, 16'h0000, 16'hFF80, 22'h000000, 1, 0, 128, 0, 0, 1, 0);
    do_cmd(6, 16'h0000, 16'h0000, 16'hFF80, 22'h000000, 1, 1, 128, 0, 0, 1, 0);
    // R3 write locked
    do_cmd(5, 16'h0003, 16'h0000, 16'hFF00, 22'h002222, 1, 1, 0, 0, 0, 0, 0);
    // R2 unloaded, and unloaded+locked write
    do_cmd(6, 16'h0003, 16'h0000, 16'hFF00, 22'h003333, 0, 0, 0, 0, 0, 0, 0);
    do_cmd(5, 16'h0003, 16'h0000, 16'hFF00, 22'h003333, 0, 1, 0, 0, 0, 0, 0);
    // R4 cylinder mismatch and read-without-header bypass
    do_cmd(1, 16'h0204, 16'h0100, 16'hFF00, 22'h000010, 1, 0, 0, 0, 0, 0, 0);
    do_cmd(7, 16'h0204, 16'h0100, 16'hFF00, 22'h000010, 1, 0, 256, 0, 0, 1, 0);
    // R5 bad sector on function 7 and function 6
    do_cmd(7, 16'h0028, 16'h0000, 16'hFF00, 22'h000010, 1, 0, 0, 0, 0, 0, 0);
    do_cmd(6, 16'h003F, 16'h0000, 16'hFF00, 22'h000010, 1, 0, 0, 0, 0, 0, 0);
    // R12 write-check mismatch, read mismatch ignored, nxm short stop
    do_cmd(1, 16'h0000, 16'h0000, 16'hFF00, 22'h000200, 1, 1, 256, 0, 1, 2, 0);
    do_cmd(6, 16'h0000, 16'h0000, 16'hFF00, 22'h000200, 1, 0, 256, 0, 1, 2, 0);
    do_cmd(6, 16'h0000, 16'h0000, 16'hFF00, 22'h000200, 1, 0, 77, 1, 0, 2, 0);
    do_cmd(5, 16'h0000, 16'h0000, 16'hFF00, 22'h000200, 1, 0, 130, 1, 0, 2, 0);
    // R9 wrap at top of address space
    do_cmd(6, 16'h0000, 16'h0000, 16'hFFFE, 22'h3FFFFE, 1, 0, 2, 0, 0, 1, 0);
    // R13 command while busy is ignored
    do_cmd(6, 16'h0010, 16'h0000, 16'hFFC0, 22'h000800, 1, 0, 64, 0, 0, 4, 1);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule